// File: doc/BRIEF.md
# Self-Triggered Channel Hit Timestamp Buffer

This block captures hit times for one channel of a free-running detector front end. There is no external trigger. The rising edge of the channel's discriminator output, which has no relation to the system clock, latches the Gray-coded timestamp bus. A free-running counter in another clock domain drives that bus. The latched word then crosses into the system clock domain through a synchronizer and is written into a small FIFO. Each stored entry carries the timestamp and two quality flags, pile-up and overflow.

A readout controller polls `rd_valid_o`. While it is high, the controller takes the oldest entry from the read outputs and pulses `pop_i` to remove it. Three controls work alongside this path. A mask input stops discriminator edges from registering. A shut-down input turns the channel off entirely. A forced-trigger input writes an entry with no discriminator edge, which lets the baseline be sampled.

Top module: `tsbuf_channel`

## Requirements
- R1: A reset of at least SYNC_STAGES+1 clock cycles with `rst_ni` low empties the FIFO (`rd_valid_o` low). It also clears the pending pile-up and overflow marks, so the first entry stored after reset has both flags at 0.
- R2: A rising edge on `disc_i` latches the value of `ts_gray_i` at that edge. The entry appears on the read outputs within SYNC_STAGES+2 clock cycles, unchanged by later activity on the timestamp bus.
- R3: The FIFO holds up to DEPTH entries and hands them out oldest first. A clock edge with `pop_i` and `rd_valid_o` both high removes the head entry.
- R4: A hit or forced trigger that reaches the write stage while the FIFO already holds DEPTH entries is dropped. The next entry that is stored has `rd_ovf_o` = 1, and entries stored after it have 0.
- R5: A second discriminator edge that arrives while an earlier capture is still in flight (latched but not yet written) is not stored as an entry of its own. Instead, the next entry written has `rd_pile_o` = 1.
- R6: While `mask_i` is high, discriminator edges are ignored. The forced trigger still works.
- R7: While `shut_i` is high, the FIFO is emptied and both discriminator edges and forced triggers are ignored. No entry appears after `shut_i` returns low.
- R8: A one-cycle `force_i` pulse stores one entry holding the `ts_gray_i` value sampled on that clock edge. The entry is visible two clock edges later.
- R9: `pop_i` while the FIFO is empty has no effect.
- R10: The head entry on the read outputs stays unchanged while it is not popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| disc_i | input | 1 | Discriminator output, asynchronous; rising edge is a hit |
| ts_gray_i | input | TS_W | Gray-coded free-running timestamp |
| mask_i | input | 1 | Ignore discriminator edges |
| shut_i | input | 1 | Turn the channel off and flush it |
| force_i | input | 1 | Store an entry without a hit (system clock domain) |
| pop_i | input | 1 | Remove the head entry |
| rd_valid_o | output | 1 | FIFO not empty |
| rd_ts_o | output | TS_W | Head entry timestamp (Gray) |
| rd_pile_o | output | 1 | Head entry pile-up flag |
| rd_ovf_o | output | 1 | Head entry overflow flag |

## Verification
The bench builds the channel with TS_W = 10, DEPTH = 4 and SYNC_STAGES = 2. A depth of four lets a few directed hits fill the FIFO, so a dropped hit and the overflow flag on the following entry can be reached quickly. The bench timestamps are Gray conversions of chosen binary values whose words differ in many bits, so a wrong or late capture shows up. Two discriminator edges placed within one clock period open the pile-up window. The mask, shut-down and forced-trigger paths are each exercised against an empty read port.

// File: rtl/tsbuf_pkg.sv
// Package: shared definitions for the channel timestamp buffer.
// Assumes nothing beyond a single compile before the modules that import it.
package tsbuf_pkg;

    // Which source feeds the FIFO write port in a given cycle
    typedef enum logic [1:0] {
        WSRC_NONE  = 2'd0,
        WSRC_HIT   = 2'd1,
        WSRC_FORCE = 2'd2
    } wsrc_e;

    // Flag positions above the timestamp inside one stored word
    localparam int unsigned OVF_OFS  = 0;
    localparam int unsigned PILE_OFS = 1;
    localparam int unsigned FLAG_W   = 2;

endpackage

// File: rtl/tsbuf_sync.sv
// Module: multi-flop level synchronizer for a single bit.
// Assumes the input changes no faster than once per STAGES+1 clocks.
// Carries no reset; the consumer resets its state from the output.
module tsbuf_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    // Shift the asynchronous level through the flop chain
    always_ff @(posedge clk_i) begin
        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/tsbuf_capture.sv
// Module: asynchronous hit capture and clock-domain crossing.
// A rising disc_i edge latches the Gray timestamp and toggles a request bit.
// While that request is unacknowledged, further edges toggle a pile-up bit.
// Both toggles are synchronized into clk_i. The acknowledge follows the
// synchronized request every cycle, so it self-aligns during reset.
// Assumes arm_en_i is quasi-static relative to disc_i edges.
module tsbuf_capture #(
    parameter int unsigned TS_W        = 14,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk_i,
    input  logic            disc_i,
    input  logic [TS_W-1:0] ts_gray_i,
    input  logic            arm_en_i,
    output logic            hit_pend_o,
    output logic [TS_W-1:0] cap_ts_o,
    output logic            pile_evt_o
);
    logic            req_tgl_q;
    logic            pile_tgl_q;
    logic [TS_W-1:0] cap_ts_q;
    logic            req_sync;
    logic            pile_sync;
    logic            ack_q;
    logic            pile_ack_q;
    logic            busy;

    // A capture is in flight until the system domain acknowledges it
    assign busy = req_tgl_q ^ ack_q;

    // Discriminator domain: latch time on a free slot, else mark pile-up
    always_ff @(posedge disc_i) begin
        if (arm_en_i && !busy) begin
            cap_ts_q  <= ts_gray_i;
            req_tgl_q <= ~req_tgl_q;
        end else if (arm_en_i) begin
            pile_tgl_q <= ~pile_tgl_q;
        end
    end

    tsbuf_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk_i (clk_i),
        .d_i   (req_tgl_q),
        .q_o   (req_sync)
    );

    tsbuf_sync #(.STAGES(SYNC_STAGES)) u_pile_sync (
        .clk_i (clk_i),
        .d_i   (pile_tgl_q),
        .q_o   (pile_sync)
    );

    // Acknowledge registers track the synchronized toggles one cycle late
    always_ff @(posedge clk_i) begin
        ack_q      <= req_sync;
        pile_ack_q <= pile_sync;
    end

    assign hit_pend_o = req_sync ^ ack_q;
    assign pile_evt_o = pile_sync ^ pile_ack_q;
    assign cap_ts_o   = cap_ts_q;
endmodule

// File: rtl/tsbuf_fifo.sv
// Module: small circular FIFO with occupancy count.
// Assumes the writer never pushes when full and the reader never pops
// when empty; flush and reset clear every word and both pointers.
module tsbuf_fifo #(
    parameter int unsigned W     = 16,
    parameter int unsigned DEPTH = 4
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         flush_i,
    input  logic                         wr_en_i,
    input  logic [W-1:0]                 wr_data_i,
    input  logic                         rd_en_i,
    output logic [W-1:0]                 rd_data_o,
    output logic                         not_empty_o,
    output logic                         full_o,
    output logic [$clog2(DEPTH+1)-1:0]   fill_o
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem_q [DEPTH];
    logic [AW-1:0] wptr_q;
    logic [AW-1:0] rptr_q;
    logic [CW-1:0] fill_q;

    // Storage words: cleared on reset or flush, written at the write pointer
    for (genvar i = 0; i < DEPTH; i++) begin : g_word
        always_ff @(posedge clk_i) begin
            if (!rst_ni || flush_i) begin
                mem_q[i] <= '0;
            end else if (wr_en_i && wptr_q == AW'(i)) begin
                mem_q[i] <= wr_data_i;
            end
        end
    end

    // Pointers and occupancy, wrapping at DEPTH
    always_ff @(posedge clk_i) begin
        if (!rst_ni || flush_i) begin
            wptr_q <= '0;
            rptr_q <= '0;
            fill_q <= '0;
        end else begin
            if (wr_en_i) begin
                wptr_q <= (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
            end
            if (rd_en_i) begin
                rptr_q <= (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
            end
            case ({wr_en_i, rd_en_i})
                2'b10:   fill_q <= fill_q + 1'b1;
                2'b01:   fill_q <= fill_q - 1'b1;
                default: fill_q <= fill_q;
            endcase
        end
    end

    assign rd_data_o   = mem_q[rptr_q];
    assign not_empty_o = (fill_q != '0);
    assign full_o      = (fill_q == CW'(DEPTH));
    assign fill_o      = fill_q;
endmodule

// File: rtl/tsbuf_channel.sv
// Module: top of the per-channel self-triggered timestamp buffer.
// Arbitrates hit and forced writes into the FIFO, accumulates pile-up and
// overflow marks and attaches them to the next stored word, and applies
// mask and shut-down. Assumes reset is held for SYNC_STAGES+1 cycles and
// that force_i is synchronous to clk_i.
module tsbuf_channel
    import tsbuf_pkg::*;
#(
    parameter int unsigned TS_W        = 14,
    parameter int unsigned DEPTH       = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            disc_i,
    input  logic [TS_W-1:0] ts_gray_i,
    input  logic            mask_i,
    input  logic            shut_i,
    input  logic            force_i,
    input  logic            pop_i,
    output logic            rd_valid_o,
    output logic [TS_W-1:0] rd_ts_o,
    output logic            rd_pile_o,
    output logic            rd_ovf_o
);
    localparam int unsigned EW = TS_W + FLAG_W;
    localparam int unsigned CW = $clog2(DEPTH+1);

    logic            hit_pend;
    logic [TS_W-1:0] cap_ts;
    logic            pile_evt;
    logic            force_pend_q;
    logic [TS_W-1:0] force_ts_q;
    logic            pile_mark_q;
    logic            ovf_mark_q;
    wsrc_e           wsrc;
    logic            wr_req;
    logic            wr_ok;
    logic            drop;
    logic            full;
    logic            not_empty;
    logic            rd_en;
    logic [EW-1:0]   wr_word;
    logic [EW-1:0]   rd_word;
    logic [CW-1:0]   fill;
    logic [TS_W-1:0] wr_ts;

    tsbuf_capture #(
        .TS_W        (TS_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_capture (
        .clk_i      (clk_i),
        .disc_i     (disc_i),
        .ts_gray_i  (ts_gray_i),
        .arm_en_i   (!mask_i && !shut_i),
        .hit_pend_o (hit_pend),
        .cap_ts_o   (cap_ts),
        .pile_evt_o (pile_evt)
    );

    // Pick the write source: a synchronized hit beats a waiting force
    always_comb begin
        if (!rst_ni || shut_i) begin
            wsrc = WSRC_NONE;
        end else if (hit_pend) begin
            wsrc = WSRC_HIT;
        end else if (force_pend_q) begin
            wsrc = WSRC_FORCE;
        end else begin
            wsrc = WSRC_NONE;
        end
    end

    assign wr_req = (wsrc != WSRC_NONE);
    assign wr_ok  = wr_req && !full;
    assign drop   = wr_req && full;
    assign wr_ts  = (wsrc == WSRC_HIT) ? cap_ts : force_ts_q;

    // Assemble the stored word with the accumulated flags
    always_comb begin
        wr_word                  = '0;
        wr_word[TS_W-1:0]        = wr_ts;
        wr_word[TS_W+OVF_OFS]    = ovf_mark_q;
        wr_word[TS_W+PILE_OFS]   = pile_mark_q || pile_evt;
    end

    // Hold a forced trigger with its timestamp until the write port is free
    always_ff @(posedge clk_i) begin
        if (!rst_ni || shut_i) begin
            force_pend_q <= 1'b0;
            force_ts_q   <= '0;
        end else if (force_i) begin
            force_pend_q <= 1'b1;
            force_ts_q   <= ts_gray_i;
        end else if (wsrc == WSRC_FORCE) begin
            force_pend_q <= 1'b0;
        end
    end

    // Accumulate pile-up and overflow marks until an entry carries them
    always_ff @(posedge clk_i) begin
        if (!rst_ni || shut_i) begin
            pile_mark_q <= 1'b0;
            ovf_mark_q  <= 1'b0;
        end else if (wr_ok) begin
            pile_mark_q <= 1'b0;
            ovf_mark_q  <= 1'b0;
        end else begin
            pile_mark_q <= pile_mark_q || pile_evt;
            ovf_mark_q  <= ovf_mark_q || drop;
        end
    end

    assign rd_en = pop_i && not_empty && !shut_i;

    tsbuf_fifo #(
        .W     (EW),
        .DEPTH (DEPTH)
    ) u_fifo (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .flush_i     (shut_i),
        .wr_en_i     (wr_ok),
        .wr_data_i   (wr_word),
        .rd_en_i     (rd_en),
        .rd_data_o   (rd_word),
        .not_empty_o (not_empty),
        .full_o      (full),
        .fill_o      (fill)
    );

    assign rd_valid_o = not_empty;
    assign rd_ts_o    = rd_word[TS_W-1:0];
    assign rd_ovf_o   = rd_word[TS_W+OVF_OFS];
    assign rd_pile_o  = rd_word[TS_W+PILE_OFS];
endmodule

// File: rtl/tsbuf_channel_chk.sv
// Module: property checker bound to tsbuf_channel.
// Observes ports plus the FIFO occupancy, write grant and overflow mark.
module tsbuf_channel_chk #(
    parameter int unsigned TS_W  = 14,
    parameter int unsigned DEPTH = 4
) (
    input logic                       clk_i,
    input logic                       rst_ni,
    input logic                       shut_i,
    input logic                       pop_i,
    input logic                       rd_valid_o,
    input logic [TS_W-1:0]            rd_ts_o,
    input logic [$clog2(DEPTH+1)-1:0] fill,
    input logic                       wr_ok,
    input logic                       ovf_mark_q
);
    localparam int unsigned CW = $clog2(DEPTH+1);

    // R1: reset leaves the FIFO empty on the following cycle
    a_r1_reset_empties: assert property (@(posedge clk_i)
        !rst_ni |=> (fill == '0));

    // R3: occupancy never exceeds the depth
    a_r3_fill_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fill <= CW'(DEPTH));

    // R3: a pop without a concurrent write removes exactly one entry
    a_r3_pop_removes_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_valid_o && pop_i && !wr_ok && !shut_i) |=> (fill == $past(fill) - 1'b1));

    // R4: the overflow mark only rises after an attempt on a full FIFO
    a_r4_ovf_from_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ovf_mark_q) |-> ($past(fill) == CW'(DEPTH)));

    // R7: shut-down empties the read port on the next cycle
    a_r7_shut_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shut_i |=> !rd_valid_o);

    // R9: popping an empty FIFO with no write leaves it empty
    a_r9_pop_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!rd_valid_o && pop_i && !wr_ok) |=> !rd_valid_o);

    // R10: an unpopped head stays put
    a_r10_head_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_valid_o && !pop_i && !shut_i) |=> (rd_valid_o && $stable(rd_ts_o)));
endmodule

bind tsbuf_channel tsbuf_channel_chk #(
    .TS_W  (TS_W),
    .DEPTH (DEPTH)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shut_i     (shut_i),
    .pop_i      (pop_i),
    .rd_valid_o (rd_valid_o),
    .rd_ts_o    (rd_ts_o),
    .fill       (fill),
    .wr_ok      (wr_ok),
    .ovf_mark_q (ovf_mark_q)
);

// File: tb/tsbuf_channel_test.sv
`timescale 1ns/1ps
// Bench: directed scenarios for tsbuf_channel, one task per scenario.
module tsbuf_channel_test;
    localparam int TS_W  = 10;
    localparam int DEPTH = 4;

    logic            clk = 1'b0;
    logic            rst_ni = 1'b0;
    logic            disc_i = 1'b0;
    logic [TS_W-1:0] ts_gray_i = '0;
    logic            mask_i = 1'b0;
    logic            shut_i = 1'b0;
    logic            force_i = 1'b0;
    logic            pop_i = 1'b0;
    logic            rd_valid_o;
    logic [TS_W-1:0] rd_ts_o;
    logic            rd_pile_o;
    logic            rd_ovf_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tsbuf_channel #(.TS_W(TS_W), .DEPTH(DEPTH), .SYNC_STAGES(2)) uut (
        .clk_i (clk), .rst_ni (rst_ni), .disc_i (disc_i), .ts_gray_i (ts_gray_i),
        .mask_i (mask_i), .shut_i (shut_i), .force_i (force_i), .pop_i (pop_i),
        .rd_valid_o (rd_valid_o), .rd_ts_o (rd_ts_o),
        .rd_pile_o (rd_pile_o), .rd_ovf_o (rd_ovf_o)
    );

    function automatic logic [TS_W-1:0] gray(input int b);
        logic [TS_W-1:0] v;
        v = TS_W'(b);
        return v ^ (v >> 1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One discriminator pulse mid-cycle; bus scrambled afterwards
    task automatic hit(input logic [TS_W-1:0] ts);
        @(negedge clk);
        ts_gray_i = ts;
        #0.4 disc_i = 1'b1;
        #0.4 disc_i = 1'b0;
        #0.4 ts_gray_i = ~ts;
        cycles(5);
    endtask

    task automatic pop();
        @(negedge clk);
        pop_i = 1'b1;
        @(negedge clk);
        pop_i = 1'b0;
    endtask

    task automatic expect_head(input string req, input logic [TS_W-1:0] ts,
                               input logic pile, input logic ovf);
        check({req, " valid"}, rd_valid_o, 1);
        check({req, " ts"}, rd_ts_o, ts);
        check({req, " pile"}, rd_pile_o, pile);
        check({req, " ovf"}, rd_ovf_o, ovf);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_ni = 1'b0;
        cycles(4);
        rst_ni = 1'b1;
        cycles(1);
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 empty after reset", rd_valid_o, 0);
    endtask

    task automatic t_single();
        hit(gray(341));
        expect_head("R2 capture", gray(341), 0, 0);
        cycles(3);
        expect_head("R10 head held", gray(341), 0, 0);
        pop();
        check("R3 empty after pop", rd_valid_o, 0);
    endtask

    task automatic t_pop_empty();
        pop();
        check("R9 still empty", rd_valid_o, 0);
        hit(gray(77));
        expect_head("R9 entry after empty pop", gray(77), 0, 0);
        pop();
        check("R9 single entry", rd_valid_o, 0);
    endtask

    task automatic t_order();
        hit(gray(10)); hit(gray(600)); hit(gray(1000));
        expect_head("R3 first", gray(10), 0, 0);
        pop();
        expect_head("R3 second", gray(600), 0, 0);
        pop();
        expect_head("R3 third", gray(1000), 0, 0);
        pop();
        check("R3 drained", rd_valid_o, 0);
    endtask

    task automatic t_overflow();
        for (int i = 0; i < DEPTH; i++) hit(gray(100 + i * 37));
        hit(gray(999));
        for (int i = 0; i < DEPTH; i++) begin
            expect_head("R4 kept entry", gray(100 + i * 37), 0, 0);
            pop();
        end
        check("R4 dropped hit absent", rd_valid_o, 0);
        hit(gray(222));
        expect_head("R4 overflow flag", gray(222), 0, 1);
        pop();
        hit(gray(223));
        expect_head("R4 flag cleared", gray(223), 0, 0);
        pop();
    endtask

    task automatic t_pileup();
        @(negedge clk);
        ts_gray_i = gray(512);
        #0.3 disc_i = 1'b1;
        #0.3 disc_i = 1'b0;
        #0.3 ts_gray_i = gray(513);
        #0.3 disc_i = 1'b1;
        #0.3 disc_i = 1'b0;
        cycles(5);
        expect_head("R5 pile flag", gray(512), 1, 0);
        pop();
        check("R5 no second entry", rd_valid_o, 0);
        hit(gray(40));
        expect_head("R5 pile cleared", gray(40), 0, 0);
        pop();
    endtask

    task automatic t_force(input string req);
        @(negedge clk);
        ts_gray_i = gray(808);
        force_i = 1'b1;
        @(negedge clk);
        force_i = 1'b0;
        ts_gray_i = gray(5);
        @(negedge clk);
        expect_head(req, gray(808), 0, 0);
        pop();
        check({req, " one entry"}, rd_valid_o, 0);
    endtask

    task automatic t_mask();
        mask_i = 1'b1;
        hit(gray(300));
        check("R6 masked hit ignored", rd_valid_o, 0);
        t_force("R6 force while masked");
        mask_i = 1'b0;
    endtask

    task automatic t_shut();
        hit(gray(1)); hit(gray(2));
        @(negedge clk);
        shut_i = 1'b1;
        @(negedge clk);
        check("R7 flushed", rd_valid_o, 0);
        hit(gray(3));
        @(negedge clk);
        force_i = 1'b1;
        @(negedge clk);
        force_i = 1'b0;
        cycles(2);
        shut_i = 1'b0;
        cycles(5);
        check("R7 nothing stored while off", rd_valid_o, 0);
    endtask

    task automatic t_reset_flags();
        for (int i = 0; i <= DEPTH; i++) hit(gray(50 + i));
        do_reset();
        check("R1 reset empties full FIFO", rd_valid_o, 0);
        hit(gray(700));
        expect_head("R1 marks cleared", gray(700), 0, 0);
        pop();
    endtask

    initial begin
        t_reset();
        t_single();
        t_pop_empty();
        t_order();
        t_overflow();
        t_pileup();
        t_force("R8 forced entry");
        t_mask();
        t_shut();
        t_reset_flags();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule